// File: doc/BRIEF.md
# Low-Side Gate Drive Enable and Protection Core

This synchronous core decides, once per clock, whether a single low-side power switch gate is commanded on. It combines two logic inputs: a non-inverting one that must be high and an inverting one that must be low. It also takes a set of digitized supervisory flags: two positive-rail threshold comparators forming a hysteresis band, a negative-rail OK flag, a flag saying the negative rail is programmed to zero, an over-temperature flag and a desaturation comparator.

Switching starts only on a fresh rising edge of the combined drive request after the supplies qualify, so a pulse already in progress is never started halfway through. After each turn-on, a blanking counter ignores the desaturation comparator for a set number of cycles. A desaturation trip after that window latches the gate off until the request goes inactive. A state flag, taken from the registered gate command, is high whenever the gate is off. It can therefore serve as a fault indication or as an interlock for the opposite switch of a half bridge.

Top module: `gdrv_guard`

## Requirements
- R1: `gate_on_o` goes high only one clock edge after a cycle in which `pos_in_i`=1 and `neg_in_i`=0 (drive request). A cycle with the request inactive makes `gate_on_o` low after the next edge.
- R2: `neg_in_i`=1 overrides `pos_in_i`=1 and forces the gate off. With the idle levels (`pos_in_i`=0, `neg_in_i`=1) the gate stays off.
- R3: The gate may be on only while the positive rail is qualified, the negative rail is qualified and `hot_i`=0. Otherwise `gate_on_o` is low after the next edge.
- R4: With `vneg_zero_i`=1, `vneg_ok_i` is not consulted and only the positive rail and temperature conditions apply.
- R5: After qualification is reached, the gate turns on only on a rising edge of the drive request: a `pos_in_i` rise with `neg_in_i` low, or a `neg_in_i` fall with `pos_in_i` high. A request that was already high when qualification arrived keeps the gate off.
- R6: Positive-rail qualification sets when `vpos_on_i`=1, clears when `vpos_off_i`=0 (rail below on-threshold minus the hysteresis), and holds its value while `vpos_on_i`=0 and `vpos_off_i`=1.
- R7: For `BLANK_CYCLES` clock edges after the gate turns on, `desat_i` has no effect on the gate.
- R8: With `desat_i`=1 once blanking has elapsed, the gate is off after the next edge. With `desat_i` held high from turn-on, the gate stays on for exactly `BLANK_CYCLES`+1 cycles.
- R9: A desaturation trip keeps the gate off while the request stays active. Once the request goes inactive, the next rising edge of the request turns the gate on again.
- R10: `gate_off_o` is the complement of `gate_on_o` at all times, including after reset and after a protection cut-off.
- R11: Any supply or over-temperature lockout re-arms edge qualification, so a new rising request edge is needed after the lockout clears.
- R12: When a lockout and a rising request edge fall in the same cycle, the lockout wins: the gate stays off and the edge does not arm switching.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock; also times the blanking window |
| rst_ni | input | 1 | Asynchronous active-low reset |
| pos_in_i | input | 1 | Non-inverting drive input |
| neg_in_i | input | 1 | Inverting drive input |
| vpos_on_i | input | 1 | Positive rail above its on-threshold |
| vpos_off_i | input | 1 | Positive rail above on-threshold minus hysteresis |
| vneg_ok_i | input | 1 | Negative rail has reached 80% of its programmed magnitude |
| vneg_zero_i | input | 1 | Negative rail programmed to zero; skip its check |
| hot_i | input | 1 | Over-temperature indication |
| desat_i | input | 1 | Desaturation comparator over threshold |
| gate_on_o | output | 1 | Registered gate-on command |
| gate_off_o | output | 1 | Driver-state flag, high while the gate is off |

## Verification
Two pairs of functions can act in the same cycle. A supply lockout can coincide with a rising request edge: the negative-rail flag is dropped in the cycle the request rises. The bench then expects the gate to stay off in that cycle and in the following one, which proves the edge was not remembered. A desaturation trip can coincide with the end of blanking: the comparator is held high from turn-on, and the gate must be counted high for exactly the window plus one cycle, then low. That trip must also persist while the request remains high, and clear only through a low request followed by a new rising edge.

// File: rtl/gdrv_pkg.sv
package gdrv_pkg;
  // Combined drive request: non-inverting high and inverting low.
  function automatic logic drive_req(input logic pos, input logic neg);
    return pos & ~neg;
  endfunction

  function automatic int blank_cw(input int n);
    return (n < 1) ? 1 : $clog2(n + 1);
  endfunction
endpackage

// File: rtl/gdrv_rail_hyst.sv
module gdrv_rail_hyst (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic on_i,
  input  logic above_off_i,
  output logic ok_o
);
  logic ok_q;

  // Next-state used directly so lockout acts on the same edge as other flags.
  assign ok_o = on_i | (ok_q & above_off_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ok_q <= 1'b0;
    else         ok_q <= ok_o;
  end

  a_r6_band_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_i && above_off_i) |=> (ok_q == $past(ok_q)));
  a_r6_drop_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!on_i && !above_off_i) |=> !ok_q);
endmodule

// File: rtl/gdrv_edge_arm.sv
module gdrv_edge_arm (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic run_ok_i,
  output logic start_ok_o
);
  logic req_q, armed_q, rise;

  assign rise       = req_i & ~req_q;
  assign start_ok_o = armed_q | rise;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q   <= 1'b0;
      armed_q <= 1'b0;
    end else begin
      req_q <= req_i;
      if (!run_ok_i)  armed_q <= 1'b0;
      else if (rise)  armed_q <= 1'b1;
    end
  end

  a_r5_arm_needs_edge: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!armed_q && !(req_i && !req_q)) |=> !armed_q);
  a_r11_lockout_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_ok_i |=> !armed_q);
endmodule

// File: rtl/gdrv_blank.sv
module gdrv_blank #(
  parameter int BLANK_CYCLES = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic gate_i,
  output logic done_o
);
  localparam int CW = gdrv_pkg::blank_cw(BLANK_CYCLES);
  localparam logic [CW-1:0] LIMIT = CW'(BLANK_CYCLES);

  logic [CW-1:0] cnt_q;

  assign done_o = (cnt_q == LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (!gate_i) cnt_q <= '0;
    else if (!done_o) cnt_q <= cnt_q + 1'b1;
  end

  a_r7_cnt_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LIMIT);
  a_r7_restart_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gate_i |=> (cnt_q == '0));
endmodule

// File: rtl/gdrv_guard.sv
module gdrv_guard #(
  parameter int BLANK_CYCLES = 50
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pos_in_i,
  input  logic neg_in_i,
  input  logic vpos_on_i,
  input  logic vpos_off_i,
  input  logic vneg_ok_i,
  input  logic vneg_zero_i,
  input  logic hot_i,
  input  logic desat_i,
  output logic gate_on_o,
  output logic gate_off_o
);
  logic req, rail_ok, run_ok, start_ok, blank_done, trip;
  logic gate_q, fault_q;

  assign req = gdrv_pkg::drive_req(pos_in_i, neg_in_i);

  gdrv_rail_hyst u_rail (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .on_i       (vpos_on_i),
    .above_off_i(vpos_off_i),
    .ok_o       (rail_ok)
  );

  assign run_ok = rail_ok & (vneg_ok_i | vneg_zero_i) & ~hot_i;

  gdrv_edge_arm u_arm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req),
    .run_ok_i  (run_ok),
    .start_ok_o(start_ok)
  );

  gdrv_blank #(.BLANK_CYCLES(BLANK_CYCLES)) u_blank (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .gate_i(gate_q),
    .done_o(blank_done)
  );

  assign trip = gate_q & blank_done & desat_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gate_q  <= 1'b0;
      fault_q <= 1'b0;
    end else begin
      gate_q  <= run_ok & req & start_ok & ~fault_q & ~trip;
      // Trip latch clears once the request goes inactive.
      fault_q <= req & (fault_q | trip);
    end
  end

  assign gate_on_o  = gate_q;
  assign gate_off_o = ~gate_q;

  a_r1_req_low_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(pos_in_i && !neg_in_i) |=> !gate_on_o);
  a_r3_lockout_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hot_i || !vpos_off_i || (!vneg_ok_i && !vneg_zero_i)) |=> !gate_on_o);
  a_r7_blank_ignore: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q && !blank_done && req && run_ok && !fault_q) |=> gate_q);
  a_r8_trip_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gate_q && blank_done && desat_i) |=> !gate_on_o);
  a_r9_latch_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fault_q && req) |=> !gate_on_o);
  a_r10_flag_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({gate_on_o, gate_off_o}));
endmodule

// File: tb/gdrv_guard_test.sv
module gdrv_guard_test;
  localparam int BLANK = 50;
  localparam int NV = 20;
  // {pos, neg, von, voff, nok, nzero, hot, desat, expected gate}
  localparam logic [8:0] VEC [NV] = '{
    9'b0_1_1_1_1_0_0_0_0, // 0  R2 idle levels, rails good
    9'b1_0_1_1_1_0_0_0_1, // 1  R1 R5 rising request starts
    9'b1_1_1_1_1_0_0_0_0, // 2  R2 inverting input overrides
    9'b1_0_1_1_1_0_0_0_1, // 3  R5 inverting falling edge restarts
    9'b0_0_1_1_1_0_0_0_0, // 4  R1 request low
    9'b1_0_1_1_1_0_1_0_0, // 5  R3 over-temperature
    9'b1_0_1_1_1_0_0_0_0, // 6  R11 no edge after clear
    9'b0_0_1_1_1_0_0_0_0, // 7  R1
    9'b1_0_1_1_1_0_0_0_1, // 8  R11 fresh edge resumes
    9'b1_0_0_1_1_0_0_0_1, // 9  R6 inside band holds
    9'b1_0_0_0_1_0_0_0_0, // 10 R6 below band drops
    9'b1_0_0_1_1_0_0_0_0, // 11 R6 band does not restore
    9'b0_0_1_1_1_0_0_0_0, // 12 R6
    9'b1_0_1_1_1_0_0_0_1, // 13 R6 above on-threshold restores
    9'b1_0_1_1_0_0_0_0_0, // 14 R3 negative rail not ok
    9'b0_0_1_1_0_1_0_0_0, // 15 R4
    9'b1_0_1_1_0_1_0_0_1, // 16 R4 zero-volt rail bypasses check
    9'b0_0_1_1_1_0_0_0_0, // 17 R1
    9'b1_0_1_1_0_0_0_0_0, // 18 R12 lockout with rising edge
    9'b1_0_1_1_1_0_0_0_0  // 19 R12 edge not remembered
  };

  logic clk = 1'b0, rst_ni = 1'b0;
  logic pos_in = 1'b0, neg_in = 1'b1, von = 1'b0, voff = 1'b0;
  logic nok = 1'b0, nzero = 1'b0, hot = 1'b0, desat = 1'b0;
  logic gate_on, gate_off;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  gdrv_guard #(.BLANK_CYCLES(BLANK)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .pos_in_i(pos_in), .neg_in_i(neg_in),
    .vpos_on_i(von), .vpos_off_i(voff), .vneg_ok_i(nok), .vneg_zero_i(nzero),
    .hot_i(hot), .desat_i(desat), .gate_on_o(gate_on), .gate_off_o(gate_off)
  );

  task automatic check(input string req, input logic exp);
    checks++;
    if (gate_on !== exp || gate_off !== ~exp) begin
      errors++;
      $display("FAIL %s: gate_on=%b gate_off=%b expected gate_on=%b gate_off=%b",
               req, gate_on, gate_off, exp, ~exp);
    end
  endtask

  task automatic step(input logic [7:0] v);
    @(negedge clk);
    {pos_in, neg_in, von, voff, nok, nzero, hot, desat} = v;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R10 reset state", 1'b0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][8:1]);
      check($sformatf("R1-table vector %0d", i), VEC[i][0]);
    end

    // R7/R8: desat held high from turn-on
    step(8'b0_0_1_1_1_0_0_0);
    check("R1 idle before desat run", 1'b0);
    step(8'b1_0_1_1_1_0_0_1);
    check("R7 turn-on with desat high", 1'b1);
    for (int k = 1; k <= BLANK; k++) begin
      step(8'b1_0_1_1_1_0_0_1);
      check($sformatf("R7 blanking cycle %0d", k), 1'b1);
    end
    step(8'b1_0_1_1_1_0_0_1);
    check("R8 trip after blanking", 1'b0);
    check("R10 flag after protection cut", 1'b0);
    // R9: latch holds while request stays high
    step(8'b1_0_1_1_1_0_0_0);
    check("R9 latch holds", 1'b0);
    step(8'b1_0_1_1_1_0_0_0);
    check("R9 latch holds second cycle", 1'b0);
    step(8'b0_0_1_1_1_0_0_0);
    check("R9 request released", 1'b0);
    step(8'b1_0_1_1_1_0_0_0);
    check("R9 new edge clears latch", 1'b1);
    // R7: late desat pulse inside a new window ignored
    step(8'b1_0_1_1_1_0_0_1);
    check("R7 desat early in window", 1'b1);
    step(8'b0_1_1_1_1_0_0_0);
    check("R2 idle levels at end", 1'b0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule